// File: doc/BRIEF.md
# Linear Pointer Data Port

This peripheral gives an 8-bit processor with a 16-bit address bus access to every byte of a 128 KB memory. It holds a 17-bit linear pointer that software loads one byte at a time. A set of data-port registers then moves data at the pointed-to location. One port moves a byte and leaves the pointer alone. A second moves a byte and then steps the pointer by one. A third moves a big-endian 16-bit word and then steps the pointer by two. An offset register adds a signed byte to the pointer in a single write, which makes it easy to walk tables forward or backward.

Register accesses are single-cycle requests on `cpu_rd` / `cpu_wr`, and each one is answered by a one-cycle `cpu_ack` pulse. Pointer and offset registers answer one cycle after acceptance. Data-port accesses run through a sequencer that issues one memory cycle per byte and keeps `cpu_busy` high until the last byte is done. The sequencer's states are `ST_IDLE`, `ST_FIRST`, `ST_SECOND` and `ST_FINISH`.
- `ST_IDLE` accepts a request. A data-port request moves it to `ST_FIRST`; any other request is acknowledged while it stays in `ST_IDLE`.
- `ST_FIRST` issues the memory cycle at the pointer. It then goes to `ST_SECOND` for a word access, or to `ST_FINISH` for a byte access.
- `ST_SECOND` captures the first byte and issues the memory cycle at pointer+1. It always goes to `ST_FINISH`.
- `ST_FINISH` captures the last byte, applies any post-increment and always returns to `ST_IDLE`, where the acknowledge is raised.

The memory answers a read with its data in the cycle after the request.

Top module: `linptr_port`

## Requirements
- R1: Register selects are encoded as follows: 0 = pointer bit 16, 1 = pointer bits 15:8, 2 = pointer bits 7:0, 3 = byte port, 4 = byte port with post-increment, 5 = word port with post-increment, 6 = signed offset, 7 = reserved. After reset the pointer is zero. In select 0, only bit 0 is stored; bits 7:1 read as zero and ignore writes.
- R2: Writing select 1 or 2 replaces only that pointer byte. The same byte reads back in `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` zero.
- R3: A read or write through select 3 moves one byte at the pointer address and leaves the pointer unchanged. A read returns the byte in `cpu_rdata[7:0]`.
- R4: A read or write through select 4 moves one byte at the pointer address and then adds 1 to the pointer.
- R5: Select 5 moves the byte at the pointer as the high byte (`cpu_rdata[15:8]` / `cpu_wdata[15:8]`) and the byte at pointer+1 as the low byte, then adds 2 to the pointer. With bytes 0x51 and 0x52 at 0x10000, a word read returns 0x5152 and leaves the pointer at 0x10002.
- R6: Writing select 6 adds the sign-extended `cpu_wdata[7:0]` (-128 to +127) to the pointer. For example, 0x100FF plus 0x05 gives 0x10104, and adding 0xFB takes it back.
- R7: All pointer arithmetic carries across byte boundaries and wraps modulo 2^17. Examples: 0x1FFFF+1 gives 0, a word access at 0x1FFFF uses 0x00000 for its second byte, and 0x00003 plus 0x80 gives 0x1FF83.
- R8: Reading select 6 or 7 returns zero, and a write to select 7 leaves the pointer unchanged.
- R9: `cpu_busy` stays high for exactly 2 cycles after a byte-port request is accepted and 3 cycles after a word-port request; it stays low for register requests. `cpu_ack` pulses in the first cycle with `cpu_busy` low. Requests made while busy are ignored.
- R10: Each byte moved costs exactly one `mem_req` cycle. The address is the pointer, or pointer+1 for the second byte of a word. `mem_we` is high only for writes, and memory is never requested otherwise.
- R11: A pointer write accepted in one cycle is used by a data-port request accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | Register read request |
| cpu_wr | input | 1 | Register write request |
| cpu_sel | input | 3 | Register select |
| cpu_wdata | input | 16 | Write data; the low byte is used for byte registers |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ack` |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | A data transfer is in progress |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the request |

## Verification
The bench checks carries out of the low pointer byte and the wrap at both ends of the 128 KB space. A design with a narrow adder or without sign extension would land the pointer on the wrong page or in the wrong direction. Word accesses are checked for byte order and for the second address at the top of memory, where a swapped or unwrapped design returns transposed data or drives an address out of range. A pointer write is followed in the very next cycle by a data access, and requests are injected while busy. These catch stale pointer use and requests that slip in mid-transfer. Exact busy lengths and per-byte memory cycles catch extra or missing memory cycles.

// File: rtl/lap_pkg.sv
package lap_pkg;

    typedef enum logic [2:0] {
        SEL_PTR_HI   = 3'd0,
        SEL_PTR_MID  = 3'd1,
        SEL_PTR_LO   = 3'd2,
        SEL_BYTE     = 3'd3,
        SEL_BYTE_INC = 3'd4,
        SEL_WORD_INC = 3'd5,
        SEL_ADD      = 3'd6,
        SEL_RSVD     = 3'd7
    } lap_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FINISH = 2'd3
    } lap_state_e;

    typedef enum logic [1:0] {
        OP_BYTE     = 2'd0,
        OP_BYTE_INC = 2'd1,
        OP_WORD_INC = 2'd2
    } xfer_op_e;

endpackage

// File: rtl/lap_ptr_unit.sv
module lap_ptr_unit #(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_hi,
    input  logic              ld_mid,
    input  logic              ld_lo,
    input  logic [7:0]        ld_val,
    input  logic              add_en,
    input  logic [7:0]        add_val,
    input  logic              step_en,
    input  logic              step_two,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [ADDR_W-1:0] ptr_plus1_o
);
    localparam int HI_W  = ADDR_W - 16;
    localparam int EXT_W = ADDR_W - 8;

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;
    logic [ADDR_W-1:0] offs_ext;
    logic [ADDR_W-1:0] step_amt;

    assign offs_ext = {{EXT_W{add_val[7]}}, add_val};
    assign step_amt = step_two ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        ptr_d = ptr_q;
        if (ld_hi) begin
            ptr_d[ADDR_W-1:16] = ld_val[HI_W-1:0];
        end
        if (ld_mid) begin
            ptr_d[15:8] = ld_val;
        end
        if (ld_lo) begin
            ptr_d[7:0] = ld_val;
        end
        if (add_en) begin
            ptr_d = ptr_q + offs_ext;
        end
        if (step_en) begin
            ptr_d = ptr_q + step_amt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o       = ptr_q;
    assign ptr_plus1_o = ptr_q + ADDR_W'(1);

    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_two && !add_en && !ld_hi && !ld_mid && !ld_lo && (&ptr_q))
        |=> (ptr_q == '0));

    // R2
    lo_load_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_lo && !ld_mid && !ld_hi && !add_en && !step_en)
        |=> $stable(ptr_q[ADDR_W-1:8]));

    // R6
    zero_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && add_val == 8'h00 && !step_en)
        |=> $stable(ptr_q));

endmodule

// File: rtl/lap_seq_fsm.sv
module lap_seq_fsm
    import lap_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [2:0]        req_sel,
    input  logic [15:0]       req_wdata,
    input  logic [ADDR_W-1:0] ptr,
    input  logic [ADDR_W-1:0] ptr_plus1,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              ack,
    output logic [15:0]       rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              ld_hi,
    output logic              ld_mid,
    output logic              ld_lo,
    output logic [7:0]        ld_val,
    output logic              add_en,
    output logic [7:0]        add_val,
    output logic              step_en,
    output logic              step_two
);
    localparam int HI_W  = ADDR_W - 16;
    localparam int PAD_W = 8 - HI_W;

    lap_state_e state_q, state_d;
    xfer_op_e   op_q;
    logic       wr_q;
    logic [15:0] wdata_q;
    logic [7:0]  hi_byte_q;
    logic        ack_q;
    logic [15:0] rdata_q;

    lap_sel_e sel;
    logic     accept;
    logic     is_data;
    logic     is_write;
    logic [15:0] reg_rd_val;

    assign sel      = lap_sel_e'(req_sel);
    assign accept   = (req_rd || req_wr) && (state_q == ST_IDLE);
    assign is_write = req_wr;
    assign is_data  = (sel == SEL_BYTE) || (sel == SEL_BYTE_INC) || (sel == SEL_WORD_INC);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && is_data) begin
                    state_d = ST_FIRST;
                end
            end
            ST_FIRST: begin
                if (op_q == OP_WORD_INC) begin
                    state_d = ST_SECOND;
                end else begin
                    state_d = ST_FINISH;
                end
            end
            ST_SECOND: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = ptr;
        mem_wdata = wdata_q[7:0];
        step_en   = 1'b0;
        step_two  = (op_q == OP_WORD_INC);
        unique case (state_q)
            ST_IDLE: begin
                mem_req = 1'b0;
            end
            ST_FIRST: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
                if (op_q == OP_WORD_INC) begin
                    mem_wdata = wdata_q[15:8];
                end
            end
            ST_SECOND: begin
                mem_req   = 1'b1;
                mem_addr  = ptr_plus1;
                mem_wdata = wdata_q[7:0];
            end
            ST_FINISH: begin
                step_en = (op_q != OP_BYTE);
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
        mem_we = mem_req && wr_q;
        busy   = (state_q != ST_IDLE);
        ld_hi  = accept && is_write && (sel == SEL_PTR_HI);
        ld_mid = accept && is_write && (sel == SEL_PTR_MID);
        ld_lo  = accept && is_write && (sel == SEL_PTR_LO);
        add_en = accept && is_write && (sel == SEL_ADD);
        ld_val = req_wdata[7:0];
        add_val = req_wdata[7:0];
    end

    // register readback value
    always_comb begin
        reg_rd_val = 16'h0000;
        unique case (sel)
            SEL_PTR_HI:  reg_rd_val = {8'h00, {PAD_W{1'b0}}, ptr[ADDR_W-1:16]};
            SEL_PTR_MID: reg_rd_val = {8'h00, ptr[15:8]};
            SEL_PTR_LO:  reg_rd_val = {8'h00, ptr[7:0]};
            default:     reg_rd_val = 16'h0000;
        endcase
    end

    // transfer data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q      <= OP_BYTE;
            wr_q      <= 1'b0;
            wdata_q   <= '0;
            hi_byte_q <= '0;
            ack_q     <= 1'b0;
            rdata_q   <= '0;
        end else begin
            ack_q <= (accept && !is_data) || (state_q == ST_FINISH);
            if (accept) begin
                wr_q    <= is_write;
                wdata_q <= req_wdata;
                if (sel == SEL_WORD_INC) begin
                    op_q <= OP_WORD_INC;
                end else if (sel == SEL_BYTE_INC) begin
                    op_q <= OP_BYTE_INC;
                end else begin
                    op_q <= OP_BYTE;
                end
                if (!is_data) begin
                    rdata_q <= is_write ? 16'h0000 : reg_rd_val;
                end
            end
            if (state_q == ST_SECOND) begin
                hi_byte_q <= mem_rdata;
            end
            if (state_q == ST_FINISH) begin
                if (wr_q) begin
                    rdata_q <= 16'h0000;
                end else if (op_q == OP_WORD_INC) begin
                    rdata_q <= {hi_byte_q, mem_rdata};
                end else begin
                    rdata_q <= {8'h00, mem_rdata};
                end
            end
        end
    end

    assign ack   = ack_q;
    assign rdata = rdata_q;

    // R5
    second_follows_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |-> ($past(state_q) == ST_FIRST));

    // R9
    ack_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> (state_q == ST_IDLE));

    // R9
    busy_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    // R10
    mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

endmodule

// File: rtl/linptr_port.sv
module linptr_port
    import lap_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [2:0]        cpu_sel,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_ack,
    output logic              cpu_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] ptr_plus1;
    logic              ld_hi, ld_mid, ld_lo;
    logic [7:0]        ld_val;
    logic              add_en;
    logic [7:0]        add_val;
    logic              step_en, step_two;

    lap_ptr_unit #(.ADDR_W(ADDR_W)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_hi       (ld_hi),
        .ld_mid      (ld_mid),
        .ld_lo       (ld_lo),
        .ld_val      (ld_val),
        .add_en      (add_en),
        .add_val     (add_val),
        .step_en     (step_en),
        .step_two    (step_two),
        .ptr_o       (ptr),
        .ptr_plus1_o (ptr_plus1)
    );

    lap_seq_fsm #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (cpu_rd),
        .req_wr    (cpu_wr),
        .req_sel   (cpu_sel),
        .req_wdata (cpu_wdata),
        .ptr       (ptr),
        .ptr_plus1 (ptr_plus1),
        .mem_rdata (mem_rdata),
        .busy      (cpu_busy),
        .ack       (cpu_ack),
        .rdata     (cpu_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .ld_hi     (ld_hi),
        .ld_mid    (ld_mid),
        .ld_lo     (ld_lo),
        .ld_val    (ld_val),
        .add_en    (add_en),
        .add_val   (add_val),
        .step_en   (step_en),
        .step_two  (step_two)
    );

    // R10
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    // R9
    no_ptr_change_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy && !step_en) |=> $stable(ptr));

endmodule

// File: tb/linptr_port_tb.sv
`timescale 1ns/1ps
module linptr_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_sel = 3'd0;
    logic [15:0] cpu_wdata = 16'h0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack, cpu_busy;
    logic        mem_req, mem_we;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;

    always #2.5 clk = ~clk;

    linptr_port #(.ADDR_W(17)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .cpu_busy(cpu_busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct { logic [15:0] data; string tag; } exp_t;
    typedef struct { logic [16:0] addr; logic we; logic [7:0] wd; string tag; } mexp_t;
    exp_t  sb_q[$];
    mexp_t mq[$];

    logic [7:0] store [int];
    logic [16:0] m_ptr = 17'h0;
    logic [7:0] pend_rd = 8'h00;

    function automatic logic [7:0] peek(input logic [16:0] a);
        if (store.exists(int'(a))) return store[int'(a)];
        return a[7:0] ^ a[15:8] ^ (a[16] ? 8'h5A : 8'h00);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // memory model and memory-side monitor
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (mq.size() == 0) begin
                check("R10 unexpected memory cycle", {15'h0, mem_addr}, 32'h0);
            end else begin
                mexp_t e;
                e = mq.pop_front();
                check({e.tag, " addr"}, {15'h0, mem_addr}, {15'h0, e.addr});
                check({e.tag, " we"}, {31'h0, mem_we}, {31'h0, e.we});
                if (e.we) check({e.tag, " wdata"}, {24'h0, mem_wdata}, {24'h0, e.wd});
            end
            if (mem_we) store[int'(mem_addr)] = mem_wdata;
            else pend_rd = peek(mem_addr);
        end
    end
    always @(posedge clk) mem_rdata <= pend_rd;

    // result monitor
    always @(negedge clk) begin
        if (rst_n && cpu_ack) begin
            if (sb_q.size() == 0) begin
                check("R9 unexpected ack", {16'h0, cpu_rdata}, 32'h0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, {16'h0, cpu_rdata}, {16'h0, e.data});
            end
        end
    end

    // model update and expectation push
    task automatic post(input logic [2:0] sel, input bit wr, input logic [15:0] wd, input string tag);
        exp_t  e;
        mexp_t m;
        e.tag = tag;
        e.data = 16'h0;
        m.tag = {tag, " mem"};
        case (sel)
            3'd0: begin
                if (wr) m_ptr[16] = wd[0];
                else e.data = {15'h0, m_ptr[16]};
            end
            3'd1: begin
                if (wr) m_ptr[15:8] = wd[7:0];
                else e.data = {8'h0, m_ptr[15:8]};
            end
            3'd2: begin
                if (wr) m_ptr[7:0] = wd[7:0];
                else e.data = {8'h0, m_ptr[7:0]};
            end
            3'd3, 3'd4: begin
                m.addr = m_ptr; m.we = wr; m.wd = wd[7:0]; mq.push_back(m);
                if (!wr) e.data = {8'h0, peek(m_ptr)};
                if (sel == 3'd4) m_ptr = m_ptr + 17'd1;
            end
            3'd5: begin
                m.addr = m_ptr; m.we = wr; m.wd = wd[15:8]; mq.push_back(m);
                m.addr = m_ptr + 17'd1; m.wd = wd[7:0]; mq.push_back(m);
                if (!wr) e.data = {peek(m_ptr), peek(m_ptr + 17'd1)};
                m_ptr = m_ptr + 17'd2;
            end
            3'd6: begin
                if (wr) m_ptr = m_ptr + {{9{wd[7]}}, wd[7:0]};
            end
            default: e.data = 16'h0;
        endcase
        sb_q.push_back(e);
    endtask

    task automatic drain();
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    task automatic access(input logic [2:0] sel, input bit wr, input logic [15:0] wd,
                          input string tag, output int busy_n);
        @(negedge clk);
        post(sel, wr, wd, tag);
        cpu_sel = sel; cpu_wdata = wd; cpu_wr = wr; cpu_rd = !wr;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        busy_n = 0;
        while (cpu_busy) begin
            busy_n++;
            @(negedge clk);
        end
        drain();
    endtask

    task automatic acc(input logic [2:0] sel, input bit wr, input logic [15:0] wd, input string tag);
        int b;
        access(sel, wr, wd, tag, b);
    endtask

    task automatic set_ptr(input logic [16:0] p);
        acc(3'd0, 1'b1, {15'h0, p[16]}, "R1 set hi");
        acc(3'd1, 1'b1, {8'h0, p[15:8]}, "R2 set mid");
        acc(3'd2, 1'b1, {8'h0, p[7:0]}, "R2 set lo");
    endtask

    task automatic read_ptr(input string tag);
        acc(3'd0, 1'b0, 16'h0, {tag, " hi"});
        acc(3'd1, 1'b0, 16'h0, {tag, " mid"});
        acc(3'd2, 1'b0, 16'h0, {tag, " lo"});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check("R1 reset busy", {31'h0, cpu_busy}, 32'h0);
        check("R1 reset ack", {31'h0, cpu_ack}, 32'h0);
        check("R10 reset mem_req", {31'h0, mem_req}, 32'h0);
        read_ptr("R1 reset ptr");

        // R1 unused upper bits of top register
        acc(3'd0, 1'b1, 16'h00FF, "R1 write hi ff");
        read_ptr("R1 hi masked");
        access(3'd1, 1'b1, 16'h0000, "R2 mid write", b);
        check("R9 reg busy", b, 0);
        acc(3'd2, 1'b1, 16'h0000, "R2 lo write");

        // R5 word read example
        store[32'h10000] = 8'h51;
        store[32'h10001] = 8'h52;
        access(3'd5, 1'b0, 16'h0, "R5 word read 5152", b);
        check("R9 word busy", b, 3);
        read_ptr("R5 ptr after word");

        // R3 byte port, no increment
        access(3'd3, 1'b0, 16'h0, "R3 byte read a", b);
        check("R9 byte busy", b, 2);
        acc(3'd3, 1'b0, 16'h0, "R3 byte read b");
        read_ptr("R3 ptr unchanged");

        // R6 add example and negative add
        set_ptr(17'h100FF);
        acc(3'd6, 1'b1, 16'h0005, "R6 add 05");
        read_ptr("R6 ptr 10104");
        acc(3'd6, 1'b1, 16'h00FB, "R6 add fb");
        read_ptr("R6 ptr back");

        // R4 increment with carry (R7)
        acc(3'd4, 1'b0, 16'h0, "R4 byte inc read");
        read_ptr("R7 carry into mid");

        // R7 wrap at top
        set_ptr(17'h1FFFF);
        acc(3'd4, 1'b0, 16'h0, "R7 inc at top");
        read_ptr("R7 wrapped to zero");
        set_ptr(17'h1FFFF);
        acc(3'd5, 1'b0, 16'h0, "R7 word across top");
        read_ptr("R7 word wrap ptr");
        set_ptr(17'h00003);
        acc(3'd6, 1'b1, 16'h0080, "R7 add 80 wrap down");
        read_ptr("R7 ptr 1ff83");

        // R3 byte write then read back
        set_ptr(17'h0A5A0);
        acc(3'd3, 1'b1, 16'h00A5, "R3 byte write");
        acc(3'd3, 1'b0, 16'h0, "R3 byte readback");
        // R4 increment on write
        acc(3'd4, 1'b1, 16'h003C, "R4 byte inc write");
        read_ptr("R4 ptr after write");
        // R5 word write ordering
        set_ptr(17'h12340);
        acc(3'd5, 1'b1, 16'hC3D4, "R5 word write");
        set_ptr(17'h12340);
        acc(3'd4, 1'b0, 16'h0, "R5 high byte first");
        acc(3'd4, 1'b0, 16'h0, "R5 low byte second");

        // R8 add/reserved reads and ignored reserved write
        acc(3'd6, 1'b0, 16'h0, "R8 add reg reads zero");
        acc(3'd7, 1'b0, 16'h0, "R8 reserved reads zero");
        acc(3'd7, 1'b1, 16'h0077, "R8 reserved write");
        read_ptr("R8 ptr untouched");

        // R11 pointer write followed next cycle by data access
        @(negedge clk);
        post(3'd2, 1'b1, 16'h0055, "R11 lo write");
        cpu_sel = 3'd2; cpu_wdata = 16'h0055; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        post(3'd3, 1'b0, 16'h0, "R11 byte read new ptr");
        cpu_sel = 3'd3; cpu_wr = 1'b0; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        drain();

        // R9 requests while busy are ignored
        @(negedge clk);
        post(3'd5, 1'b0, 16'h0, "R9 word read busy test");
        cpu_sel = 3'd5; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_sel = 3'd2; cpu_wdata = 16'h00EE;
        @(negedge clk);
        cpu_sel = 3'd6; cpu_wdata = 16'h0040;
        @(negedge clk);
        cpu_wr = 1'b0;
        drain();
        read_ptr("R9 ptr after ignored writes");

        // R4 R6 walk over a table
        set_ptr(17'h0FFF0);
        for (int i = 0; i < 12; i++) begin
            acc(3'd4, 1'b0, 16'h0, "R4 walk read");
            acc(3'd6, 1'b1, {8'h0, 8'(i * 7 - 20)}, "R6 walk add");
        end
        read_ptr("R6 walk end ptr");

        repeat (3) @(negedge clk);
        check("R10 no leftover mem cycles", mq.size(), 0);
        finish_run();
    end

endmodule